// File: doc/BRIEF.md
# Two-Channel Bitstream Decimator with DC Removal

This block is the digital back end of a stereo oversampled audio converter. Each channel delivers a single-bit noise-shaped stream at 64 times the output sample rate. The block turns each stream into 24-bit two's-complement PCM at the base rate. A fifth-order boxcar (sinc) decimator strips the shaped high-frequency noise and drops the rate by 64. A first-order recursive high-pass section then removes any DC offset, and the result is clamped to the 24-bit range.

Both channels run in lock-step lanes. A single strobe marks each new left/right pair so that a downstream serial formatter can interleave the two words. The input strobe `bit_valid` qualifies every input bit, so the bitstream clock can be slower than the core clock and need not be regular.

Top module: `dsd_decim_hpf`

## Requirements
- R1: A bit value of 1 enters the filter as +1 and a bit value of 0 enters as -1. A constant 1 stream settles to a decimator output of +2^30 and a constant 0 stream settles to -2^30.
- R2: Input bits are consumed only on clock cycles where `bit_valid` is high. The values of `bit_l` and `bit_r` in other cycles have no effect on any output.
- R3: Each group of 64 accepted bits, counted from reset, yields exactly one output pair. `out_valid` is high for one cycle, starting after the third rising edge counted from the edge that accepts the 64th bit of the group.
- R4: The decimator output for group m equals the sum over k of h[k]*x[64m+63-k]. Here h is the 316-tap kernel made by convolving five length-64 all-ones windows, and inputs before reset count as 0. That sum is shifted right arithmetically by 7 bits to give the high-pass input s.
- R5: The high-pass state follows y[m] = s[m] - s[m-1] + y[m-1] - (y[m-1] >>> 12), with s[-1] = y[-1] = 0 after reset. The state y is kept unclamped.
- R6: Each output word is y[m] clamped to the range -8388608 .. +8388607 (hex 800000 .. 7FFFFF) instead of wrapping.
- R7: The left and right lanes are computed independently. The `pcm_l` result depends only on `bit_l`, and the `pcm_r` result depends only on `bit_r`.
- R8: A synchronous active-low reset clears all integrator, comb, high-pass and output state and the group counter. On the cycle after reset is released, both PCM outputs read 0 and `out_valid` is low.
- R9: `pcm_l` and `pcm_r` hold their values on every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_valid | input | 1 | Qualifies bit_l and bit_r for this cycle |
| bit_l | input | 1 | Left-channel modulator bit |
| bit_r | input | 1 | Right-channel modulator bit |
| pcm_l | output | 24 | Left-channel PCM word, two's complement |
| pcm_r | output | 24 | Right-channel PCM word, two's complement |
| out_valid | output | 1 | One-cycle strobe marking a new left/right pair |

## Verification
The hardest state to reach from the ports is output saturation. A constant stream alone settles just inside full scale, because the high-pass has already bled some of the level away before the decimator reaches its peak. Saturation only occurs when the input steps from one full-scale extreme to the other. The stimulus therefore holds each lane at one rail for eight groups, so that the high-pass state sits near that rail, and then flips the stream. The step of about 2^24 in s then pushes y past the opposite limit. A second hard case is a reset partway through a group. The bench feeds 100 bits, pulses reset, and checks that the next group boundary falls exactly 64 accepted bits later, with zero filter history.

// File: rtl/dsd_pkg.sv
// Package: shared constants and helpers for the bitstream decimator.
// Assumes: decimation ratio is a power of two, given by its log2.
package dsd_pkg;

    // Accumulator width for an ORDER-stage sinc decimator of ratio 2^RLOG2.
    // One extra bit beyond the classic bound so +full-scale is representable.
    function automatic int cic_acc_width(input int order, input int rlog2);
        return order * rlog2 + 2;
    endfunction

    // Right shift that maps the decimator's full-scale gain onto OUT_W bits.
    function automatic int cic_out_shift(input int order, input int rlog2, input int out_w);
        return order * rlog2 - (out_w - 1);
    endfunction

endpackage

// File: rtl/dsd_cic_integ.sv
// Module: dsd_cic_integ
// Integrator cascade of a sinc decimator, running at the input bit rate.
// Maps bit 1 to +1 and bit 0 to -1. The stages are chained through their next
// values, so acc_out holds the full cascade sum including the last accepted bit.
// Assumes: ACC_W is wide enough for the decimated result; the intermediate
// sums wrap modulo 2^ACC_W, which the comb section cancels exactly.
module dsd_cic_integ #(
    parameter int ORDER = 5,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    bit_in,
    output logic signed [ACC_W-1:0] acc_out
);

    localparam logic signed [ACC_W-1:0] STEP_UP   = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] STEP_DOWN = '1;

    logic signed [ACC_W-1:0] acc_q [ORDER];
    logic signed [ACC_W-1:0] acc_d [ORDER];

    // Next value of every stage: first stage adds the mapped bit, others add the stage before.
    always_comb begin
        acc_d[0] = acc_q[0] + (bit_in ? STEP_UP : STEP_DOWN);
        for (int k = 1; k < ORDER; k++) begin
            acc_d[k] = acc_q[k] + acc_d[k-1];
        end
    end

    // Stage registers: cleared by reset, advanced only on accepted bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ORDER; k++) acc_q[k] <= '0;
        end else if (en) begin
            for (int k = 0; k < ORDER; k++) acc_q[k] <= acc_d[k];
        end
    end

    assign acc_out = acc_q[ORDER-1];

endmodule

// File: rtl/dsd_cic_comb.sv
// Module: dsd_cic_comb
// Comb cascade of a sinc decimator, running once per output sample.
// Each stage subtracts the previous decimated value of its own input.
// Assumes: en pulses once per decimation period, with din stable on that cycle.
module dsd_cic_comb #(
    parameter int ORDER = 5,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [ACC_W-1:0] dout,
    output logic                    dout_vld
);

    logic signed [ACC_W-1:0] dly_q [ORDER];
    logic signed [ACC_W-1:0] stage [ORDER+1];

    assign stage[0] = din;

    // One differencing stage per filter order.
    for (genvar g = 0; g < ORDER; g++) begin : g_diff
        assign stage[g+1] = stage[g] - dly_q[g];
    end

    // Delay registers and the registered decimator result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ORDER; k++) dly_q[k] <= '0;
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= en;
            if (en) begin
                for (int k = 0; k < ORDER; k++) dly_q[k] <= stage[k];
                dout <= stage[ORDER];
            end
        end
    end

endmodule

// File: rtl/dsd_dc_block.sv
// Module: dsd_dc_block
// DC-removing first-order high-pass with output saturation.
// y[n] = x[n] - x[n-1] + y[n-1] - (y[n-1] >>> POLE_SH), where x = din >>> IN_SH.
// The state is kept unclamped at ST_W bits; only the output word is clamped.
// Assumes: IN_W - IN_SH + 2 <= ST_W so the scaled input and state never wrap.
module dsd_dc_block #(
    parameter int IN_W    = 32,
    parameter int IN_SH   = 7,
    parameter int OUT_W   = 24,
    parameter int POLE_SH = 12,
    parameter int ST_W    = OUT_W + 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [IN_W-1:0]  din,
    output logic [OUT_W-1:0]        pcm,
    output logic                    pcm_vld
);

    localparam logic signed [ST_W-1:0] SAT_HI = ST_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
    localparam logic signed [ST_W-1:0] SAT_LO = ST_W'(-(64'sd1 <<< (OUT_W-1)));

    logic signed [IN_W-1:0] scaled;
    logic signed [ST_W-1:0] x_cur;
    logic signed [ST_W-1:0] x_prev_q;
    logic signed [ST_W-1:0] y_q;
    logic signed [ST_W-1:0] y_new;
    logic [OUT_W-1:0]       clamped;

    assign scaled = din >>> IN_SH;
    assign x_cur  = ST_W'(scaled);

    // Recursion: differentiate the input, leak the state toward zero.
    always_comb begin
        y_new = x_cur - x_prev_q + y_q - (y_q >>> POLE_SH);
    end

    // Clamp the new state into the signed output range.
    always_comb begin
        if (y_new > SAT_HI) begin
            clamped = SAT_HI[OUT_W-1:0];
        end else if (y_new < SAT_LO) begin
            clamped = SAT_LO[OUT_W-1:0];
        end else begin
            clamped = y_new[OUT_W-1:0];
        end
    end

    // Filter state and output registers, updated once per decimated sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_prev_q <= '0;
            y_q      <= '0;
            pcm      <= '0;
            pcm_vld  <= 1'b0;
        end else begin
            pcm_vld <= en;
            if (en) begin
                x_prev_q <= x_cur;
                y_q      <= y_new;
                pcm      <= clamped;
            end
        end
    end

endmodule

// File: rtl/dsd_decim_hpf.sv
// Module: dsd_decim_hpf (top)
// Stereo single-bit to PCM converter: a sinc^ORDER decimator of ratio 2^RLOG2
// followed by a DC-blocking high-pass and clamp, one lane per channel.
// A shared phase counter decides when a group of 2^RLOG2 accepted bits completes.
// Assumes: bit_valid may be high on any cycle; bits on other cycles are ignored.
module dsd_decim_hpf #(
    parameter int ORDER   = 5,
    parameter int RLOG2   = 6,
    parameter int OUT_W   = 24,
    parameter int POLE_SH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_l,
    input  logic             bit_r,
    output logic [OUT_W-1:0] pcm_l,
    output logic [OUT_W-1:0] pcm_r,
    output logic             out_valid
);

    import dsd_pkg::*;

    localparam int NCH   = 2;
    localparam int ACC_W = cic_acc_width(ORDER, RLOG2);
    localparam int IN_SH = cic_out_shift(ORDER, RLOG2, OUT_W);

    logic [RLOG2-1:0]        phase_q;
    logic                    dec_q;
    logic [NCH-1:0]          bits;
    logic [NCH-1:0]          lane_vld;
    logic [OUT_W-1:0]        lane_pcm [NCH];

    assign bits = {bit_r, bit_l};

    // Group phase: counts accepted bits and flags the last bit of each group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            dec_q   <= 1'b0;
        end else begin
            dec_q <= bit_valid && (phase_q == '1);
            if (bit_valid) phase_q <= phase_q + 1'b1;
        end
    end

    // One independent filter lane per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic signed [ACC_W-1:0] integ_out;
        logic signed [ACC_W-1:0] comb_out;
        logic                    comb_vld;

        dsd_cic_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) integ_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (bit_valid),
            .bit_in  (bits[c]),
            .acc_out (integ_out)
        );

        dsd_cic_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) comb_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (dec_q),
            .din      (integ_out),
            .dout     (comb_out),
            .dout_vld (comb_vld)
        );

        dsd_dc_block #(
            .IN_W    (ACC_W),
            .IN_SH   (IN_SH),
            .OUT_W   (OUT_W),
            .POLE_SH (POLE_SH)
        ) dcb_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (comb_vld),
            .din     (comb_out),
            .pcm     (lane_pcm[c]),
            .pcm_vld (lane_vld[c])
        );
    end

    assign pcm_l     = lane_pcm[0];
    assign pcm_r     = lane_pcm[1];
    assign out_valid = &lane_vld;

endmodule

// File: rtl/dsd_decim_hpf_chk.sv
// Module: dsd_decim_hpf_chk
// Port-level protocol checks for dsd_decim_hpf, attached by bind.
// Keeps its own count of accepted bits to predict each output strobe.
module dsd_decim_hpf_chk #(
    parameter int RLOG2 = 6,
    parameter int OUT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] pcm_l,
    input logic [OUT_W-1:0] pcm_r
);

    logic [RLOG2-1:0] seen_q;
    logic [2:0]       last_bit_q;

    // Independent accepted-bit count and a three-deep record of group ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= '0;
            last_bit_q <= '0;
        end else begin
            last_bit_q <= {last_bit_q[1:0], bit_valid && (seen_q == '1)};
            if (bit_valid) seen_q <= seen_q + 1'b1;
        end
    end

    // R3
    strobe_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == last_bit_q[2]);

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R9
    pcm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(pcm_l) && $stable(pcm_r)));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (!out_valid && pcm_l == '0 && pcm_r == '0));

endmodule

bind dsd_decim_hpf dsd_decim_hpf_chk #(.RLOG2(RLOG2), .OUT_W(OUT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .out_valid (out_valid),
    .pcm_l     (pcm_l),
    .pcm_r     (pcm_r)
);

// File: tb/dsd_decim_hpf_tb.sv
`timescale 1ns/1ps
// Directed bench for dsd_decim_hpf with a convolution reference model.
module dsd_decim_hpf_tb_top;

    localparam int KLEN = 316;
    localparam int HMAX = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_l = 1'b0;
    logic        bit_r = 1'b0;
    logic [23:0] pcm_l;
    logic [23:0] pcm_r;
    logic        out_valid;

    int checks = 0;
    int errors = 0;

    longint hk [KLEN];
    int     hist_l [HMAX];
    int     hist_r [HMAX];
    int     nacc;
    longint xp_l, y_l, xp_r, y_r;
    longint last_l, last_r;
    int     top_hits, bot_hits;

    always #4 clk = ~clk;

    dsd_decim_hpf dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_l     (bit_l),
        .bit_r     (bit_r),
        .pcm_l     (pcm_l),
        .pcm_r     (pcm_r),
        .out_valid (out_valid)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat24(input longint v);
        if (v > 64'sd8388607) return 64'sd8388607;
        if (v < -64'sd8388608) return -64'sd8388608;
        return v;
    endfunction

    function automatic longint as_signed(input logic [23:0] w);
        return longint'($signed(w));
    endfunction

    function automatic longint cic_ref(input bit right, input int n);
        longint acc = 0;
        for (int k = 0; k < KLEN; k++) begin
            if (n - k >= 0) acc += hk[k] * longint'(right ? hist_r[n-k] : hist_l[n-k]);
        end
        return acc;
    endfunction

    function automatic bit pat_bit(input int p, input int n);
        logic [31:0] hv;
        hv = 32'(n) * 32'h9E3779B1;
        case (p)
            0: return 1'b1;
            1: return 1'b0;
            2: return (n % 2) == 0;
            3: return (n % 4) < 2;
            4: return (n % 4) != 0;
            5: return (n % 4) == 0;
            6: return hv[17] ^ hv[9];
            7: return hv[20];
            8: return n >= 512;
            default: return n < 512;
        endcase
    endfunction

    task automatic model_reset();
        nacc = 0;
        xp_l = 0; y_l = 0; xp_r = 0; y_r = 0;
        last_l = 0; last_r = 0;
    endtask

    // Waits for the strobe after a completed group and compares both lanes (R3, R4, R5, R6, R9).
    task automatic finish_group();
        int     seen;
        longint s_l, s_r, e_l, e_r;
        seen = 0;
        @(negedge clk);
        bit_valid = 1'b0;
        check(as_signed(pcm_l) == last_l, "R9 hold left", as_signed(pcm_l), last_l);
        for (int w = 1; w <= 8; w++) begin
            if (w > 1) @(negedge clk);
            if (out_valid) begin
                seen = w;
                break;
            end
        end
        check(seen == 3, "R3 strobe latency", seen, 3);
        s_l = cic_ref(1'b0, nacc - 1) >>> 7;
        s_r = cic_ref(1'b1, nacc - 1) >>> 7;
        y_l = s_l - xp_l + y_l - (y_l >>> 12); xp_l = s_l;
        y_r = s_r - xp_r + y_r - (y_r >>> 12); xp_r = s_r;
        e_l = sat24(y_l);
        e_r = sat24(y_r);
        check(as_signed(pcm_l) == e_l, "R4/R5/R6 left", as_signed(pcm_l), e_l);
        check(as_signed(pcm_r) == e_r, "R4/R5/R6 right R7", as_signed(pcm_r), e_r);
        if (as_signed(pcm_l) == 64'sd8388607 || as_signed(pcm_r) == 64'sd8388607) top_hits++;
        if (as_signed(pcm_l) == -64'sd8388608 || as_signed(pcm_r) == -64'sd8388608) bot_hits++;
        last_l = e_l;
        last_r = e_r;
        @(negedge clk);
        check(out_valid == 1'b0, "R3 single pulse", out_valid, 0);
    endtask

    // Presents one bit pair, then optional idle cycles carrying flipped bits (R2).
    task automatic push_bit(input bit bl, input bit br, input int gap);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_l = bl;
        bit_r = br;
        hist_l[nacc] = bl ? 1 : -1;
        hist_r[nacc] = br ? 1 : -1;
        nacc++;
        if (nacc % 64 == 0) begin
            finish_group();
        end else begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                bit_valid = 1'b0;
                bit_l = ~bl;
                bit_r = ~br;
            end
        end
    endtask

    task automatic run_stream(input int pl, input int pr, input int nbits, input int gap);
        for (int n = 0; n < nbits; n++) push_bit(pat_bit(pl, n), pat_bit(pr, n), gap);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_reset();
        check(pcm_l == 24'd0, "R8 left cleared", as_signed(pcm_l), 0);
        check(pcm_r == 24'd0, "R8 right cleared", as_signed(pcm_r), 0);
        check(out_valid == 1'b0, "R8 strobe low", out_valid, 0);
    endtask

    // R1: constant streams; right lane also confirms independence (R7).
    task automatic test_constant();
        apply_reset();
        run_stream(0, 1, 64 * 6, 0);
        check(xp_l == 64'sd8388608, "R1 plus rail scaled", xp_l, 64'sd8388608);
        check(xp_r == -64'sd8388608, "R1 minus rail scaled", xp_r, -64'sd8388608);
    endtask

    // R6: rail-to-rail steps drive both clamps.
    task automatic test_saturation();
        apply_reset();
        top_hits = 0;
        bot_hits = 0;
        run_stream(8, 9, 64 * 16, 0);
        check(top_hits > 0, "R6 upper clamp reached", top_hits, 1);
        check(bot_hits > 0, "R6 lower clamp reached", bot_hits, 1);
    endtask

    // R4, R7: periodic patterns with different content per lane.
    task automatic test_periodic();
        apply_reset();
        run_stream(2, 3, 64 * 6, 0);
    endtask

    // R2: idle cycles with changing bits between accepted bits.
    task automatic test_gaps();
        apply_reset();
        run_stream(6, 7, 64 * 6, 2);
    endtask

    // R5: unequal densities leave a DC level for the high-pass to remove.
    task automatic test_density();
        apply_reset();
        run_stream(4, 5, 64 * 10, 1);
    endtask

    // R8: reset partway through a group restarts phase and history.
    task automatic test_mid_reset();
        apply_reset();
        run_stream(6, 4, 100, 0);
        apply_reset();
        run_stream(7, 6, 64 * 4, 0);
    endtask

    initial begin
        for (int i = 0; i < KLEN; i++) hk[i] = (i < 64) ? 1 : 0;
        repeat (4) begin
            longint tmp [KLEN];
            for (int i = 0; i < KLEN; i++) begin
                tmp[i] = 0;
                for (int j = 0; j < 64; j++) if (i - j >= 0) tmp[i] += hk[i-j];
            end
            for (int i = 0; i < KLEN; i++) hk[i] = tmp[i];
        end
        model_reset();
        test_constant();
        test_saturation();
        test_periodic();
        test_gaps();
        test_density();
        test_mid_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule